// File: doc/BRIEF.md
# Shared-port multi-queue buffer

This block is a single-clock buffer with one write port and one read port in front of one shared word memory. The memory is divided into up to 16 independent FIFO queues. Each queue owns a contiguous region made of a whole number of fixed-size blocks. A static parameter table sets how many blocks each queue receives. A queue may be given zero blocks, so every capacity is a multiple of the block size.

A queue-select input on the write side chooses which queue receives the incoming word. The write side acts as a plain FIFO and reports a full flag for the queue it currently selects. A queue-select input on the read side chooses which queue feeds the output register. The read side works in first-word-fall-through style: as soon as a non-empty queue is selected, its head word moves into the output register and the valid flag rises. No read enable is needed for that first word. Each later word needs an enabled read.

A word that has been loaded into the output register counts as read. Selecting another queue replaces that word with the new queue's head. If the new queue is empty, the old word stays on the output and the valid flag goes low.

Top module: `shared_mq_buffer`

## Requirements
- R1: After reset, `rd_valid` is 0 and `rd_data` is 0. All queues are empty. `wr_full` is 0 when `wr_sel` names a queue that has blocks, and 1 when it names a queue with zero blocks.
- R2: The capacity of queue q is its block count times `BLK_WORDS`. Once that many writes have been accepted without reads, `wr_full` is 1 from the cycle after the last accepted write. It returns to 0 in the cycle after a word is removed.
- R3: A write while `wr_full` is 1 is dropped. The queue keeps exactly its earlier contents.
- R4: Words leave each queue in the order they were written. A word written to one queue never appears on the output while another queue is selected.
- R5: When `rd_valid` is 0, or `rd_sel` differs from its value in the previous cycle, the head word of the selected non-empty queue is loaded into `rd_data` without `rd_en`, and `rd_valid` is 1 after that edge. A word replaced by a queue switch counts as consumed.
- R6: `rd_en` while `rd_valid` is 1 loads the next word of the selected queue. If that queue is empty, `rd_valid` drops to 0 and `rd_data` keeps the last word.
- R7: While `rd_valid` is 1, `rd_en` is 0 and `rd_sel` is unchanged, both `rd_valid` and `rd_data` hold.
- R8: Switching `rd_sel` to an empty queue leaves `rd_data` at the previously shown word, with `rd_valid` at 0. `rd_data` never changes while `rd_valid` is 0.
- R9: A write and a read may happen in the same cycle, on the same queue or on different queues. A word written at edge k into an empty selected queue is shown at edge k+1.
- R10: A queue with zero blocks always reports `wr_full` = 1 and never makes `rd_valid` rise.
- R11: Read and write positions wrap inside each queue's own region. FIFO order survives any number of wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request for the queue named by `wr_sel` |
| wr_sel | input | SEL_W | Write-side queue number |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Selected write queue has no free space |
| rd_en | input | 1 | Advance to the next word of the selected read queue |
| rd_sel | input | SEL_W | Read-side queue number |
| rd_data | output | DATA_W | Output register |
| rd_valid | output | 1 | Output register holds a word of the selected queue |

## Verification
A short table of mixed write and read patterns covers several cases: interleaved writes, fall-through on selection, holding without an enable, draining to empty, and switching to the zero-block queue. Together these separate correct fall-through timing from a design that waits for `rd_en` or that clears the output on a switch. Fill-to-capacity runs on queues of one, two and five blocks, each followed by a dropped overflow write, show whether capacity comes from the block table and whether an extra word sneaks in. Refilling after partial drains moves the pointers across region boundaries, which exposes wrap and base-address faults. Same-cycle write and read sequences, and back-and-forth queue switches, tell apart correct consumption of a replaced word from a design that re-shows it.

// File: rtl/mqb_pkg.sv
package mqb_pkg;
   localparam int MAX_Q = 16;
   localparam int CFG_W = 8;

   // blocks given to queue q
   function automatic int blk_of(input logic [MAX_Q*CFG_W-1:0] cfg, input int q);
      return int'(cfg[q*CFG_W +: CFG_W]);
   endfunction

   // blocks owned by queues below q (region base in blocks)
   function automatic int blk_base(input logic [MAX_Q*CFG_W-1:0] cfg, input int q);
      int acc;
      acc = 0;
      for (int i = 0; i < q; i++) acc += int'(cfg[i*CFG_W +: CFG_W]);
      return acc;
   endfunction
endpackage

// File: rtl/mqb_queue_ctrl.sv
module mqb_queue_ctrl #(
   parameter int ADDR_W = 6,
   parameter int CNT_W  = 7,
   parameter int BASE   = 0,
   parameter int CAP    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              full,
   output logic              empty
);
   if (CAP == 0) begin : g_void
      // no storage: permanently full and empty
      localparam int unused_cfg = BASE + CNT_W;
      logic unused_in;
      assign unused_in = ^{clk, rst_n, push, pop};
      assign wr_addr = '0;
      assign rd_addr = '0;
      assign full    = 1'b1;
      assign empty   = 1'b1;
   end else begin : g_live
      localparam int PTR_W = (CAP > 1) ? $clog2(CAP) : 1;
      logic [PTR_W-1:0] wptr, rptr;
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
         end else begin
            if (push) wptr <= (wptr == PTR_W'(CAP-1)) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == PTR_W'(CAP-1)) ? '0 : rptr + 1'b1;
            case ({push, pop})
               2'b10:   cnt <= cnt + 1'b1;
               2'b01:   cnt <= cnt - 1'b1;
               default: ;
            endcase
         end
      end

      assign wr_addr = ADDR_W'(BASE) + ADDR_W'(wptr);
      assign rd_addr = ADDR_W'(BASE) + ADDR_W'(rptr);
      assign full    = (cnt == CNT_W'(CAP));
      assign empty   = (cnt == '0);
   end
endmodule

// File: rtl/mqb_store.sv
module mqb_store #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 64,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/mqb_out_stage.sv
module mqb_out_stage #(
   parameter int DATA_W = 16,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  rd_sel,
   input  logic              rd_en,
   input  logic              head_empty,
   input  logic [DATA_W-1:0] head_word,
   output logic              take,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   logic [SEL_W-1:0] sel_q;
   logic             want;

   // refill on empty register, explicit advance, or queue switch
   assign want = !rd_valid || rd_en || (rd_sel != sel_q);
   assign take = want && !head_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         sel_q <= rd_sel;
         if (want) begin
            rd_valid <= !head_empty;
            if (!head_empty) rd_data <= head_word;
         end
      end
   end
endmodule

// File: rtl/shared_mq_buffer.sv
module shared_mq_buffer #(
   parameter int DATA_W    = 16,
   parameter int NUM_Q     = 4,
   parameter int BLK_WORDS = 8,
   parameter int NUM_BLKS  = 8,
   parameter logic [mqb_pkg::MAX_Q*mqb_pkg::CFG_W-1:0] Q_BLOCKS =
      {96'd0, 8'd5, 8'd0, 8'd2, 8'd1},
   localparam int SEL_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_full,
   input  logic              rd_en,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   localparam int TOTAL_W = BLK_WORDS * NUM_BLKS;
   localparam int ADDR_W  = (TOTAL_W > 1) ? $clog2(TOTAL_W) : 1;
   localparam int CNT_W   = $clog2(TOTAL_W + 1);

   if (NUM_Q < 1 || NUM_Q > mqb_pkg::MAX_Q) begin : g_bad_nq
      $error("NUM_Q must lie in 1..16");
   end
   if (BLK_WORDS < 1 || NUM_BLKS < 1) begin : g_bad_geom
      $error("block size and block count must be positive");
   end
   if (mqb_pkg::blk_base(Q_BLOCKS, NUM_Q) > NUM_BLKS) begin : g_bad_alloc
      $error("queue block table exceeds the shared memory");
   end

   logic [NUM_Q-1:0]  q_full, q_empty, q_push, q_pop;
   logic [ADDR_W-1:0] q_waddr [NUM_Q];
   logic [ADDR_W-1:0] q_raddr [NUM_Q];
   logic              sel_full, head_empty, wr_ok, take;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [DATA_W-1:0] head_word;

   for (genvar g = 0; g < NUM_Q; g++) begin : g_q
      localparam int BASE = mqb_pkg::blk_base(Q_BLOCKS, g) * BLK_WORDS;
      localparam int CAP  = mqb_pkg::blk_of(Q_BLOCKS, g) * BLK_WORDS;
      assign q_push[g] = wr_ok && (int'(wr_sel) == g);
      assign q_pop[g]  = take  && (int'(rd_sel) == g);
      mqb_queue_ctrl #(
         .ADDR_W (ADDR_W),
         .CNT_W  (CNT_W),
         .BASE   (BASE),
         .CAP    (CAP)
      ) u_qc (
         .clk     (clk),
         .rst_n   (rst_n),
         .push    (q_push[g]),
         .pop     (q_pop[g]),
         .wr_addr (q_waddr[g]),
         .rd_addr (q_raddr[g]),
         .full    (q_full[g]),
         .empty   (q_empty[g])
      );
   end

   // per-side selection; an unused select code looks full and empty
   always_comb begin
      sel_full   = 1'b1;
      head_empty = 1'b1;
      waddr      = '0;
      raddr      = '0;
      for (int i = 0; i < NUM_Q; i++) begin
         if (int'(wr_sel) == i) begin
            sel_full = q_full[i];
            waddr    = q_waddr[i];
         end
         if (int'(rd_sel) == i) begin
            head_empty = q_empty[i];
            raddr      = q_raddr[i];
         end
      end
   end

   assign wr_ok   = wr_en && !sel_full;
   assign wr_full = sel_full;

   mqb_store #(
      .DATA_W (DATA_W),
      .DEPTH  (TOTAL_W),
      .ADDR_W (ADDR_W)
   ) u_store (
      .clk   (clk),
      .we    (wr_ok),
      .waddr (waddr),
      .wdata (wr_data),
      .raddr (raddr),
      .rdata (head_word)
   );

   mqb_out_stage #(
      .DATA_W (DATA_W),
      .SEL_W  (SEL_W)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_sel     (rd_sel),
      .rd_en      (rd_en),
      .head_empty (head_empty),
      .head_word  (head_word),
      .take       (take),
      .rd_data    (rd_data),
      .rd_valid   (rd_valid)
   );
endmodule

// File: rtl/mqb_checker.sv
module mqb_checker #(
   parameter int DATA_W = 16,
   parameter int NUM_Q  = 4,
   parameter int SEL_W  = 2,
   parameter logic [mqb_pkg::MAX_Q*mqb_pkg::CFG_W-1:0] Q_BLOCKS = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [SEL_W-1:0]  wr_sel,
   input logic              wr_full,
   input logic              rd_en,
   input logic [SEL_W-1:0]  rd_sel,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_valid
);
   logic [SEL_W-1:0] sel_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_prev <= '0;
      else        sel_prev <= rd_sel;
   end

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!rd_valid && rd_data == '0));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_en && rd_sel == sel_prev) |=> (rd_valid && $stable(rd_data)));

   assert_keep_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> $stable(rd_data));

   assert_void_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(wr_sel) < NUM_Q && mqb_pkg::blk_of(Q_BLOCKS, int'(wr_sel)) == 0) |-> wr_full);

   assert_void_never_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> (mqb_pkg::blk_of(Q_BLOCKS, int'($past(rd_sel))) != 0));
endmodule

bind shared_mq_buffer mqb_checker #(
   .DATA_W   (DATA_W),
   .NUM_Q    (NUM_Q),
   .SEL_W    (SEL_W),
   .Q_BLOCKS (Q_BLOCKS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_sel   (wr_sel),
   .wr_full  (wr_full),
   .rd_en    (rd_en),
   .rd_sel   (rd_sel),
   .rd_data  (rd_data),
   .rd_valid (rd_valid)
);

// File: tb/shared_mq_buffer_bench.sv
module shared_mq_buffer_bench;
   // default build: Q0 = 8 words, Q1 = 16, Q2 = none, Q3 = 40
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = 2'd0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_full;
   logic          rd_en = 1'b0;
   logic [1:0]    rd_sel = 2'd0;
   logic [DW-1:0] rd_data;
   logic          rd_valid;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   shared_mq_buffer u_shared_mq_buffer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .wr_full(wr_full), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
      .rd_valid(rd_valid)
   );

   typedef struct packed {
      logic          wr_en;
      logic [1:0]    wr_sel;
      logic [DW-1:0] wr_data;
      logic          rd_en;
      logic [1:0]    rd_sel;
      logic          exp_v;
      logic [DW-1:0] exp_d;
      logic          exp_f;
   } vec_t;

   localparam vec_t VEC [12] = '{
      '{1'b1, 2'd1, 16'h0011, 1'b0, 2'd0, 1'b0, 16'h0000, 1'b0},
      '{1'b1, 2'd1, 16'h0012, 1'b0, 2'd1, 1'b1, 16'h0011, 1'b0},
      '{1'b1, 2'd0, 16'h0021, 1'b1, 2'd1, 1'b1, 16'h0012, 1'b0},
      '{1'b0, 2'd0, 16'h0000, 1'b1, 2'd1, 1'b0, 16'h0012, 1'b0},
      '{1'b1, 2'd2, 16'h0099, 1'b0, 2'd0, 1'b1, 16'h0021, 1'b1},
      '{1'b1, 2'd3, 16'h0031, 1'b0, 2'd2, 1'b0, 16'h0021, 1'b0},
      '{1'b1, 2'd3, 16'h0032, 1'b1, 2'd2, 1'b0, 16'h0021, 1'b0},
      '{1'b0, 2'd3, 16'h0000, 1'b0, 2'd3, 1'b1, 16'h0031, 1'b0},
      '{1'b0, 2'd3, 16'h0000, 1'b0, 2'd3, 1'b1, 16'h0031, 1'b0},
      '{1'b1, 2'd3, 16'h0033, 1'b1, 2'd3, 1'b1, 16'h0032, 1'b0},
      '{1'b0, 2'd3, 16'h0000, 1'b1, 2'd3, 1'b1, 16'h0033, 1'b0},
      '{1'b0, 2'd3, 16'h0000, 1'b1, 2'd3, 1'b0, 16'h0033, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // park reading on the zero-block queue, then write n words into q
   task automatic fill(input int q, input int n, input int base, input bit ends_full);
      rd_en  = 1'b0;
      rd_sel = 2'd2;
      for (int i = 0; i < n; i++) begin
         wr_en   = 1'b1;
         wr_sel  = 2'(q);
         wr_data = 16'(base + i);
         step();
         chk("R2 wr_full after write", 32'(wr_full), 32'(ends_full && (i == n - 1)));
      end
      wr_en = 1'b0;
   endtask

   // select q and read n words in order, then one read past the end
   task automatic drain(input int q, input int n, input int base);
      rd_sel = 2'(q);
      rd_en  = 1'b0;
      step();
      chk("R5 fall-through valid", 32'(rd_valid), 32'd1);
      chk("R5 fall-through data", 32'(rd_data), 32'(16'(base)));
      for (int i = 1; i < n; i++) begin
         rd_en = 1'b1;
         step();
         chk("R4 order data", 32'(rd_data), 32'(16'(base + i)));
         chk("R4 order valid", 32'(rd_valid), 32'd1);
      end
      rd_en = 1'b1;
      step();
      chk("R6 drained valid", 32'(rd_valid), 32'd0);
      chk("R6 drained data kept", 32'(rd_data), 32'(16'(base + n - 1)));
      rd_en  = 1'b0;
      rd_sel = 2'd2;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      step();
      step();
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 rd_valid", 32'(rd_valid), 32'd0);
      chk("R1 rd_data", 32'(rd_data), 32'd0);
      chk("R1 wr_full queue with blocks", 32'(wr_full), 32'd0);
      wr_sel = 2'd2;
      #1;
      chk("R1 R10 wr_full zero-block queue", 32'(wr_full), 32'd1);
      wr_sel = 2'd0;

      // table of mixed patterns
      for (int i = 0; i < 12; i++) begin
         wr_en   = VEC[i].wr_en;
         wr_sel  = VEC[i].wr_sel;
         wr_data = VEC[i].wr_data;
         rd_en   = VEC[i].rd_en;
         rd_sel  = VEC[i].rd_sel;
         step();
         chk($sformatf("table row %0d R5 R6 R7 R8 R10 valid", i), 32'(rd_valid), 32'(VEC[i].exp_v));
         chk($sformatf("table row %0d R4 R6 R8 data", i), 32'(rd_data), 32'(VEC[i].exp_d));
         chk($sformatf("table row %0d R2 R10 full", i), 32'(wr_full), 32'(VEC[i].exp_f));
      end
      wr_en  = 1'b0;
      rd_en  = 1'b0;
      rd_sel = 2'd2;
      step();

      // R2 R3: one-block queue to capacity, overflow dropped
      fill(0, 8, 'h40, 1'b1);
      wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'hEEEE;
      step();
      chk("R3 still full after dropped write", 32'(wr_full), 32'd1);
      wr_en = 1'b0;
      drain(0, 8, 'h40);
      wr_sel = 2'd0;
      #1;
      chk("R2 full cleared after reads", 32'(wr_full), 32'd0);

      // R11 wrap in the one-block region
      fill(0, 5, 'h50, 1'b0);
      drain(0, 5, 'h50);
      fill(0, 8, 'h58, 1'b1);
      drain(0, 8, 'h58);

      // R2 R3 R11 five-block and two-block queues
      fill(3, 40, 'h100, 1'b1);
      wr_en = 1'b1; wr_sel = 2'd3; wr_data = 16'hEEEE;
      step();
      chk("R3 overflow on large queue", 32'(wr_full), 32'd1);
      wr_en = 1'b0;
      drain(3, 40, 'h100);
      fill(3, 3, 'h180, 1'b0);
      drain(3, 3, 'h180);
      fill(1, 16, 'h200, 1'b1);
      drain(1, 16, 'h200);

      // R4 independence of queues
      fill(0, 3, 'h300, 1'b0);
      fill(3, 2, 'h400, 1'b0);
      drain(3, 2, 'h400);
      drain(0, 3, 'h300);

      // R9 same-cycle writes and reads
      rd_sel = 2'd1; rd_en = 1'b0;
      wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'h00A0;
      step();
      chk("R9 not yet visible", 32'(rd_valid), 32'd0);
      wr_data = 16'h00A1;
      step();
      chk("R9 shown next edge valid", 32'(rd_valid), 32'd1);
      chk("R9 shown next edge data", 32'(rd_data), 32'h00A0);
      wr_sel = 2'd0; wr_data = 16'h00B0; rd_en = 1'b1;
      step();
      chk("R9 read with write to other queue", 32'(rd_data), 32'h00A1);
      wr_sel = 2'd1; wr_data = 16'h00A2;
      step();
      chk("R9 same-queue write not yet readable", 32'(rd_valid), 32'd0);
      chk("R9 data kept", 32'(rd_data), 32'h00A1);
      wr_en = 1'b0; rd_en = 1'b0;
      step();
      chk("R9 refill valid", 32'(rd_valid), 32'd1);
      chk("R9 refill data", 32'(rd_data), 32'h00A2);
      rd_en = 1'b1;
      step();
      chk("R6 empty after read", 32'(rd_valid), 32'd0);
      rd_en = 1'b0; rd_sel = 2'd2;
      step();
      drain(0, 1, 'hB0);

      // R5 R8 switches consume and keep words
      fill(0, 2, 'h60, 1'b0);
      fill(3, 1, 'h70, 1'b0);
      rd_sel = 2'd0;
      step();
      chk("R5 select Q0", 32'(rd_data), 32'h0060);
      rd_sel = 2'd3;
      step();
      chk("R5 switch to Q3", 32'(rd_data), 32'h0070);
      rd_sel = 2'd0;
      step();
      chk("R5 replaced word consumed", 32'(rd_data), 32'h0061);
      chk("R5 valid after switch", 32'(rd_valid), 32'd1);
      rd_sel = 2'd3;
      step();
      chk("R8 switch to empty valid", 32'(rd_valid), 32'd0);
      chk("R8 switch to empty data", 32'(rd_data), 32'h0061);
      rd_sel = 2'd0;
      step();
      chk("R5 consumed word not shown again", 32'(rd_valid), 32'd0);
      chk("R8 data still held", 32'(rd_data), 32'h0061);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule